// File: doc/BRIEF.md
# Sequenced One-Bit Register ALU Controller

This block computes one of four logic results from two one-bit operands through a small register datapath and leaves the answer in an operand register. The datapath has three operand registers (R0, R1, R2) and an accumulator (R3). Each operand register loads through a two-way input mux that picks either its external pin or the accumulator. A four-way operand mux feeds the second ALU input, and an eight-function ALU writes into the accumulator. A finite-state controller drives every load enable, clear, mux select and ALU code.

A request starts with a one-cycle strobe on `start`. The two operation-select bits are captured at that moment. The controller then runs a fixed micro-sequence:

1. Load the operands.
2. Copy the first operand into the accumulator.
3. Combine it with the second operand. NAND takes one extra invert step here.
4. Write the accumulator back into R2.

A one-cycle `done` pulse marks the write-back. R2 then holds until the next write-back or reset. The datapath width is a parameter, with a default of one bit. With a wider setting, the carry-in is replicated across the width.

Top module: `alu1_seq_top`

## Requirements
- R1: While `rst_async` is high, `busy`, `done` and `r2_out` are 0 regardless of the clock. Asserting it in the middle of a request abandons that request, and no `done` follows.
- R2: `op_sel` = 2'b00 gives `r2_out` = `m0 | ~m1 | cin`.
- R3: `op_sel` = 2'b01 gives `r2_out` = `~(m0 & m1)`.
- R4: `op_sel` = 2'b10 gives `r2_out` = `m0 | m1`.
- R5: `op_sel` = 2'b11 gives `r2_out` = `m0 ^ m1`.
- R6: If `start` is sampled at clock edge E0 while idle, `done` is high for exactly one cycle, starting right after edge E0+4. For `op_sel` 2'b01 it starts after edge E0+5 instead. The new `r2_out` is visible in that same cycle.
- R7: `r2_out` changes only in a cycle where `done` is high. Changing `m0`, `m1`, `m2` or `cin` while idle leaves it unchanged, and `m2` never reaches it.
- R8: A `start` strobe that arrives while `busy` is high is ignored. The running result and latency are unchanged, and no further `done` follows.
- R9: `op_sel` is captured when `start` is accepted. Changing it during a request does not alter that request's result or latency.
- R10: `busy` is high from the cycle after `start` is accepted up to the write-back edge, and it is low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_async | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Request strobe, sampled only while idle |
| op_sel | input | 2 | Operation select, captured with `start` |
| m0 | input | W | External input of R0 (first operand) |
| m1 | input | W | External input of R1 (second operand) |
| m2 | input | W | External input of R2's input mux |
| cin | input | 1 | Carry-in used by ALU codes 000 and 001 |
| r2_out | output | W | Contents of R2, the result register |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when R2 has been written |

## Verification
The assertions assume that `rst_async` changes away from the active clock edge. They also assume that `m0`, `m1` and `cin` do not change while `busy` is high. The controller reads `m0` and `m1` in the load step and `cin` in the combine step, so the result is defined only for operands that are held for the whole request.

The bench drives every input on the falling edge. It keeps the operands fixed from the start strobe until `done` has been seen. Only `op_sel`, `start` and the reset are moved mid-request, which is exactly what R1, R8 and R9 cover.

// File: rtl/alu1_pkg.sv
package alu1_pkg;

    localparam int NUM_OPND = 3;
    localparam int NUM_REG  = NUM_OPND + 1;
    localparam int ACC_IDX  = NUM_OPND;

    // ALU function codes; A is the accumulator, B the operand-mux output
    typedef enum logic [2:0] {
        ALU_OR_CIN  = 3'b000,  // A | B | cin
        ALU_ORN_CIN = 3'b001,  // A | ~B | cin
        ALU_PASS_B  = 3'b010,  // B
        ALU_ANDN    = 3'b011,  // A & ~B
        ALU_AND     = 3'b100,  // A & B
        ALU_OR      = 3'b101,  // A | B
        ALU_NOT_A   = 3'b110,  // ~A
        ALU_XOR     = 3'b111   // A ^ B
    } alu_code_e;

    typedef enum logic [1:0] {
        BSEL_R0   = 2'b00,
        BSEL_R1   = 2'b01,
        BSEL_R2   = 2'b10,
        BSEL_ZERO = 2'b11
    } bsel_e;

    typedef enum logic [1:0] {
        OP_ORN_CIN = 2'b00,
        OP_NAND    = 2'b01,
        OP_OR      = 2'b10,
        OP_XOR     = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PASS,
        ST_COMB,
        ST_INV,
        ST_WB
    } state_e;

    typedef struct packed {
        logic [NUM_REG-1:0]  ld;      // per-register load enable
        logic [NUM_REG-1:0]  clr;     // per-register synchronous clear
        logic [NUM_OPND-1:0] in_acc;  // operand input mux: 1 = accumulator
        bsel_e               bsel;
        alu_code_e           code;
    } dp_ctrl_t;

    localparam dp_ctrl_t DP_IDLE = '{
        ld:     '0,
        clr:    '0,
        in_acc: '0,
        bsel:   BSEL_ZERO,
        code:   ALU_PASS_B
    };

endpackage

// File: rtl/alu1_alu.sv
module alu1_alu
    import alu1_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_code_e    code,
    output logic [W-1:0] y
);

    logic [W-1:0] cin_vec;

    assign cin_vec = {W{cin}};

    always_comb begin
        case (code)
            ALU_OR_CIN:  y = a | b | cin_vec;
            ALU_ORN_CIN: y = a | ~b | cin_vec;
            ALU_PASS_B:  y = b;
            ALU_ANDN:    y = a & ~b;
            ALU_AND:     y = a & b;
            ALU_OR:      y = a | b;
            ALU_NOT_A:   y = ~a;
            ALU_XOR:     y = a ^ b;
            default:     y = '0;
        endcase
    end

endmodule

// File: rtl/alu1_datapath.sv
module alu1_datapath
    import alu1_pkg::*;
#(
    parameter int W = 1
) (
    input  logic                         clk,
    input  logic                         rst_async,
    input  dp_ctrl_t                     ctrl,
    input  logic [NUM_OPND-1:0][W-1:0]   ext_in,
    input  logic                         cin,
    output logic [NUM_REG-1:0][W-1:0]    regs_o
);

    logic [NUM_REG-1:0][W-1:0] regs_d, regs_q;
    logic [NUM_REG-1:0][W-1:0] load_val;
    logic [W-1:0]              opnd_b;

    // per-register two-way input mux
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_in_mux
        assign load_val[g] = ctrl.in_acc[g] ? regs_q[ACC_IDX] : ext_in[g];
    end

    // operand mux for ALU input B
    always_comb begin
        case (ctrl.bsel)
            BSEL_R0:  opnd_b = regs_q[0];
            BSEL_R1:  opnd_b = regs_q[1];
            BSEL_R2:  opnd_b = regs_q[2];
            default:  opnd_b = '0;
        endcase
    end

    alu1_alu #(.W(W)) u_alu (
        .a    (regs_q[ACC_IDX]),
        .b    (opnd_b),
        .cin  (cin),
        .code (ctrl.code),
        .y    (load_val[ACC_IDX])
    );

    // load beats clear, otherwise hold
    always_comb begin
        for (int i = 0; i < NUM_REG; i++) begin
            if (ctrl.ld[i])       regs_d[i] = load_val[i];
            else if (ctrl.clr[i]) regs_d[i] = '0;
            else                  regs_d[i] = regs_q[i];
        end
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) regs_q <= '0;
        else           regs_q <= regs_d;
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/alu1_ctrl.sv
module alu1_ctrl
    import alu1_pkg::*;
(
    input  logic       clk,
    input  logic       rst_async,
    input  logic       start,
    input  logic [1:0] op_sel,
    output dp_ctrl_t   dp,
    output op_e        op_o,
    output logic       busy,
    output logic       done
);

    typedef struct packed {
        state_e st;
        op_e    op;
        logic   done;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_IDLE, op: OP_ORN_CIN, done: 1'b0};

    ctl_t ctl_d, ctl_q;

    function automatic alu_code_e comb_code(input op_e op);
        case (op)
            OP_ORN_CIN: return ALU_ORN_CIN;
            OP_NAND:    return ALU_AND;
            OP_OR:      return ALU_OR;
            default:    return ALU_XOR;
        endcase
    endfunction

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        dp         = DP_IDLE;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st = ST_LOAD;
                    ctl_d.op = op_e'(op_sel);
                end
            end
            ST_LOAD: begin
                dp.ld[0]        = 1'b1;
                dp.ld[1]        = 1'b1;
                dp.clr[ACC_IDX] = 1'b1;
                ctl_d.st        = ST_PASS;
            end
            ST_PASS: begin
                dp.bsel       = BSEL_R0;
                dp.code       = ALU_PASS_B;
                dp.ld[ACC_IDX] = 1'b1;
                ctl_d.st      = ST_COMB;
            end
            ST_COMB: begin
                dp.bsel        = BSEL_R1;
                dp.code        = comb_code(ctl_q.op);
                dp.ld[ACC_IDX] = 1'b1;
                ctl_d.st       = (ctl_q.op == OP_NAND) ? ST_INV : ST_WB;
            end
            ST_INV: begin
                dp.code        = ALU_NOT_A;
                dp.ld[ACC_IDX] = 1'b1;
                ctl_d.st       = ST_WB;
            end
            ST_WB: begin
                dp.in_acc[2] = 1'b1;
                dp.ld[2]     = 1'b1;
                ctl_d.done   = 1'b1;
                ctl_d.st     = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) ctl_q <= CTL_RESET;
        else           ctl_q <= ctl_d;
    end

    assign busy = (ctl_q.st != ST_IDLE);
    assign done = ctl_q.done;
    assign op_o = ctl_q.op;

endmodule

// File: rtl/alu1_seq_top.sv
module alu1_seq_top
    import alu1_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_async,
    input  logic         start,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] m0,
    input  logic [W-1:0] m1,
    input  logic [W-1:0] m2,
    input  logic         cin,
    output logic [W-1:0] r2_out,
    output logic         busy,
    output logic         done
);

    dp_ctrl_t                  dp_ctrl;
    op_e                       op_latched;
    logic [NUM_OPND-1:0][W-1:0] ext_bus;
    logic [NUM_REG-1:0][W-1:0]  regs;

    assign ext_bus[0] = m0;
    assign ext_bus[1] = m1;
    assign ext_bus[2] = m2;

    alu1_ctrl u_ctrl (
        .clk       (clk),
        .rst_async (rst_async),
        .start     (start),
        .op_sel    (op_sel),
        .dp        (dp_ctrl),
        .op_o      (op_latched),
        .busy      (busy),
        .done      (done)
    );

    alu1_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_async (rst_async),
        .ctrl      (dp_ctrl),
        .ext_in    (ext_bus),
        .cin       (cin),
        .regs_o    (regs)
    );

    assign r2_out = regs[2];

endmodule

// File: rtl/alu1_seq_sva.sv
module alu1_seq_sva
    import alu1_pkg::*;
#(
    parameter int W = 1
) (
    input logic         clk,
    input logic         rst_async,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] r2_out,
    input op_e          op_q
);

    // length of the current busy run, used in place of a long $past window
    logic [3:0] busy_len_q;

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async)    busy_len_q <= '0;
        else if (busy)    busy_len_q <= busy_len_q + 4'd1;
        else              busy_len_q <= '0;
    end

    // R1: reset holds the outputs quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst_async |-> (!busy && !done && r2_out == '0));

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst_async)
        done |=> !done);

    // R6: four busy cycles, five for the NAND path
    p_latency_r6: assert property (@(posedge clk) disable iff (rst_async)
        done |-> (busy_len_q == ((op_q == OP_NAND) ? 4'd5 : 4'd4)));

    // R7: result register moves only on a write-back
    p_r2_hold_r7: assert property (@(posedge clk) disable iff (rst_async)
        !$stable(r2_out) |-> done);

    // R9: captured operation stays fixed through a request
    p_op_hold_r9: assert property (@(posedge clk) disable iff (rst_async)
        (busy && $past(busy)) |-> $stable(op_q));

    // R10: an accepted start raises busy
    p_start_busy_r10: assert property (@(posedge clk) disable iff (rst_async)
        (start && !busy) |=> busy);

    // R10: done only at the end of a busy run
    p_done_end_r10: assert property (@(posedge clk) disable iff (rst_async)
        done |-> (!busy && $past(busy)));

endmodule

bind alu1_seq_top alu1_seq_sva #(.W(W)) u_sva (
    .clk       (clk),
    .rst_async (rst_async),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .r2_out    (r2_out),
    .op_q      (op_latched)
);

// File: tb/tb_alu1_seq_top.sv
module tb_alu1_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 50000;

    logic       clk = 1'b0;
    logic       rst_async;
    logic       start;
    logic [1:0] op_sel;
    logic       m0, m1, m2, cin;
    logic       r2_out, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    alu1_seq_top #(.W(1)) dut (
        .clk       (clk),
        .rst_async (rst_async),
        .start     (start),
        .op_sel    (op_sel),
        .m0        (m0),
        .m1        (m1),
        .m2        (m2),
        .cin       (cin),
        .r2_out    (r2_out),
        .busy      (busy),
        .done      (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic ref_fn(input logic [1:0] op, input logic a, b, c);
        case (op)
            2'b00:   return a | ~b | c;
            2'b01:   return ~(a & b);
            2'b10:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Runs one request; optional poke of op_sel/start at falling edge poke_at
    task automatic run_req(input logic [1:0] op, input logic a, b, c,
                           input int poke_at, input bit poke_start,
                           input logic [1:0] poke_op,
                           output logic res, output int lat, output bit busy_gap);
        @(negedge clk);
        op_sel = op; m0 = a; m1 = b; cin = c; start = 1'b1;
        lat = 0;
        busy_gap = 1'b0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (lat == poke_at) begin
                op_sel = poke_op;
                start  = poke_start;
            end
            if (!done && !busy) busy_gap = 1'b1;
        end
        res = r2_out;
        chk(!busy, "R10 busy low with done", int'(busy), 0);
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R6 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset_state();
        chk(!busy, "R1 busy in reset", int'(busy), 0);
        chk(!done, "R1 done in reset", int'(done), 0);
        chk(r2_out == 1'b0, "R1 r2 in reset", int'(r2_out), 0);
    endtask

    task automatic t_all_ops();
        logic res; int lat; bit gap;
        for (int op = 0; op < 4; op++) begin
            for (int v = 0; v < 8; v++) begin
                run_req(2'(op), v[2], v[1], v[0], 0, 1'b0, 2'b00, res, lat, gap);
                chk(res == ref_fn(2'(op), v[2], v[1], v[0]), op_tag(2'(op)),
                    int'(res), int'(ref_fn(2'(op), v[2], v[1], v[0])));
                chk(lat == ((op == 1) ? 6 : 5), "R6 latency", lat, (op == 1) ? 6 : 5);
                chk(!gap, "R10 busy through request", int'(gap), 0);
            end
        end
    endtask

    task automatic t_hold_idle();
        logic res; int lat; bit gap;
        run_req(2'b10, 1'b1, 1'b0, 1'b0, 0, 1'b0, 2'b00, res, lat, gap);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            m0 = k[0]; m1 = ~k[0]; m2 = ~k[1]; cin = k[1];
        end
        @(negedge clk);
        chk(r2_out == 1'b1, "R7 r2 holds while idle", int'(r2_out), 1);
        run_req(2'b11, 1'b1, 1'b1, 1'b0, 0, 1'b0, 2'b00, res, lat, gap);
        m2 = 1'b1;
        repeat (4) @(negedge clk);
        chk(r2_out == 1'b0, "R7 m2 not loaded", int'(r2_out), 0);
    endtask

    task automatic t_start_while_busy();
        logic res; int lat; bit gap;
        // XOR of 1,1 = 0; OR would give 1
        run_req(2'b11, 1'b1, 1'b1, 1'b0, 2, 1'b1, 2'b10, res, lat, gap);
        chk(res == 1'b0, "R8 result kept", int'(res), 0);
        chk(lat == 5, "R8 latency kept", lat, 5);
        begin
            int extra = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk(extra == 0, "R8 no second request", extra, 0);
        end
    endtask

    task automatic t_sel_change();
        logic res; int lat; bit gap;
        // OR of 1,1 = 1; switch to XOR (0) mid-flight
        run_req(2'b10, 1'b1, 1'b1, 1'b0, 1, 1'b0, 2'b11, res, lat, gap);
        chk(res == 1'b1, "R9 op captured", int'(res), 1);
        // NAND of 0,1 = 1; switch to OR (1) but latency must stay 6
        run_req(2'b01, 1'b0, 1'b1, 1'b0, 2, 1'b0, 2'b10, res, lat, gap);
        chk(res == 1'b1, "R9 NAND result", int'(res), 1);
        chk(lat == 6, "R9 NAND latency kept", lat, 6);
    endtask

    task automatic t_reset_mid();
        logic res; int lat; bit gap;
        run_req(2'b10, 1'b1, 1'b0, 1'b0, 0, 1'b0, 2'b00, res, lat, gap);
        chk(r2_out == 1'b1, "R1 r2 set before reset", int'(r2_out), 1);
        @(negedge clk);
        op_sel = 2'b11; m0 = 1'b1; m1 = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        #1 rst_async = 1'b1;
        #1;
        chk(!busy, "R1 busy cleared async", int'(busy), 0);
        chk(r2_out == 1'b0, "R1 r2 cleared async", int'(r2_out), 0);
        @(negedge clk);
        rst_async = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done || busy) seen++;
            end
            chk(seen == 0, "R1 request abandoned", seen, 0);
        end
        run_req(2'b00, 1'b0, 1'b1, 1'b1, 0, 1'b0, 2'b00, res, lat, gap);
        chk(res == 1'b1, "R2 after reset", int'(res), 1);
    endtask

    initial begin
        rst_async = 1'b1;
        start = 1'b0; op_sel = 2'b00;
        m0 = 1'b0; m1 = 1'b0; m2 = 1'b0; cin = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_async = 1'b0;
        @(negedge clk);
        t_all_ops();
        t_hold_idle();
        t_start_while_busy();
        t_sel_change();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule